// File: doc/BRIEF.md
# Receive Frame DMA Channel with Descriptor Chains

This block is one receive channel of a frame DMA engine. It takes frames from a byte stream that marks the last byte of each frame. It stores them in memory buffers that software describes through a linked chain of control blocks. The channel reaches memory through a single word-addressed port. That port returns read data one cycle after the request and performs a write in the same cycle it is asked for.

Each control block sits at a word address `B`:
- The link to the next block is at `B+0`.
- A setup word is at `B+1`.
- Each buffer slot `k` has its buffer address at `B+2+2k` and its completion word at `B+3+2k`.

The channel fills one slot at a time and packs the bytes into 32-bit words. When a slot closes, the channel writes the byte count and the frame-position flags back into that slot's completion word. A link with bit 0 set ends the chain: the channel parks there and holds the stream off until software reloads it. An interrupt pending flag records completed slots. A write-1 acknowledge clears that flag, and an enable masks the interrupt output.

Top module: `rxdma_channel`

## Requirements
- R1: A control block at word address B holds the link at B+0, the setup word at B+1, and for slot k (0 to cfg_slots-1) the buffer address at B+2+2k and the completion word at B+3+2k. After the last slot the link is read and, when valid, becomes the next block.
- R2: Setup word bits 15:0 give the buffer size of every slot of the block in bytes, and bit 18 requests an interrupt for the slots of that block.
- R3: Byte i of a slot is written to word address (buffer address + i/4), in bits 8*(i%4)+7 down to 8*(i%4). A word is written when its lane 3 fills or when the slot closes, and unfilled lanes are zero.
- R4: When a slot closes, its completion word is written in the next cycle with these fields: the byte count in bits 15:0, frame start in bit 16, frame end in bit 17, the block's interrupt-request flag in bit 18, done (1) in bit 19, and zero in bits 31:20.
- R5: A slot closes when its byte count reaches the buffer size or when it takes the last byte of a frame. A longer frame continues in the next slot, and so on across blocks. Only a frame's first slot has the start flag, and only its final slot has the end flag.
- R6: A link with bit 0 set parks the channel (parked=1). While parked, in_ready stays 0, so no byte is taken or lost.
- R7: cmd_reload in the parked state re-reads the link of the current block. The channel continues if the link is now valid and parks again otherwise.
- R8: cmd_activate in the idle state loads start_ptr as the first block. It is ignored at any other time.
- R9: A closing slot sets irq_pend when the block's interrupt-request flag is 1, and, if cfg_eof_only is 1, only when the slot has the frame-end flag. irq = irq_pend AND irq_en. A 1 on irq_ack clears irq_pend one cycle later; a new set has priority.
- R10: cmd_stop lets a slot that has already taken bytes close normally and then returns to idle. In idle, buf_empty=1, in_ready=0 and no memory access is made.
- R11: After reset the channel is idle with buf_empty=1, in_ready=0, mem_req=0, irq=0 and parked=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cmd_activate | input | 1 | start the chain at start_ptr (idle only) |
| cmd_reload | input | 1 | re-read the link of a parked chain |
| cmd_stop | input | 1 | stop after the slot in progress |
| start_ptr | input | ADDR_W | word address of the first control block |
| cfg_slots | input | SLOT_W | slots used per control block, 1 to 15 |
| cfg_eof_only | input | 1 | interrupt only for slots that end a frame |
| irq_en | input | 1 | interrupt enable |
| irq_ack | input | 1 | write-1 clear of irq_pend |
| in_valid | input | 1 | stream byte valid |
| in_data | input | 8 | stream byte |
| in_last | input | 1 | byte is the last of its frame |
| in_ready | output | 1 | channel takes the byte this cycle |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | access is a write |
| mem_addr | output | ADDR_W | word address |
| mem_wdata | output | 32 | write data |
| mem_rdata | input | 32 | read data, one cycle after a read request |
| irq | output | 1 | masked interrupt |
| irq_pend | output | 1 | interrupt pending flag |
| parked | output | 1 | channel waits at an end-of-chain link |
| buf_empty | output | 1 | channel idle and fully drained |

## Verification
A data word is written in the same cycle as the byte that fills lane 3 or closes the slot. The completion word follows one cycle after the closing byte. irq_pend changes one edge after the completion write, and irq_ack takes effect at the next edge. The bench has a behavioural model that queues each expected memory write, with its address and data, before the bytes are driven. Every write the design makes is compared against the queue in the cycle it appears, so ordering and timing are checked as well as content. Flags such as irq, parked and buf_empty are sampled only after the write queue has drained and several further cycles have passed. Stalls are checked cycle by cycle while a byte is held valid.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INFO_REQ,
    ST_INFO_GET,
    ST_PTR_REQ,
    ST_PTR_GET,
    ST_STREAM,
    ST_STATUS,
    ST_NEXT_REQ,
    ST_NEXT_GET,
    ST_PARK
  } chan_state_t;

  localparam int LEN_W       = 16;
  localparam int SETUP_IRQ_B = 18;
  localparam int DONE_SOF_B  = 16;
  localparam int DONE_EOF_B  = 17;
  localparam int DONE_IRQ_B  = 18;
  localparam int DONE_FIN_B  = 19;

  // completion word: length, frame flags, interrupt copy, done; offset kept zero
  function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len,
                                              input logic sof,
                                              input logic eof,
                                              input logic intr);
    logic [31:0] w;
    w = '0;
    w[LEN_W-1:0]  = len;
    w[DONE_SOF_B] = sof;
    w[DONE_EOF_B] = eof;
    w[DONE_IRQ_B] = intr;
    w[DONE_FIN_B] = 1'b1;
    return w;
  endfunction

  // lane placement of one byte inside a 32-bit word
  function automatic logic [31:0] place_byte(input logic [7:0] b, input logic [1:0] lane);
    return 32'(b) << {lane, 3'b000};
  endfunction

endpackage

// File: rtl/rxdma_packer.sv
module rxdma_packer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             flush,
  input  logic [7:0]       byte_in,
  output logic [CNT_W-1:0] cnt,
  output logic [1:0]       lane,
  output logic [31:0]      word
);
  import rxdma_pkg::*;

  logic [31:0] acc;

  assign lane = cnt[1:0];
  assign word = acc | place_byte(byte_in, lane);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (clr) begin
      acc <= '0;
      cnt <= '0;
    end else if (take) begin
      cnt <= cnt + CNT_W'(1);
      acc <= flush ? 32'h0 : word;
    end
  end

endmodule

// File: rtl/rxdma_irq.sv
module rxdma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic ack,
  input  logic en,
  output logic pend,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= evt | (pend & ~ack);
  end

  assign irq = pend & en;

endmodule

// File: rtl/rxdma_channel.sv
module rxdma_channel #(
  parameter int ADDR_W = 32,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_activate,
  input  logic              cmd_reload,
  input  logic              cmd_stop,
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic [SLOT_W-1:0] cfg_slots,
  input  logic              cfg_eof_only,
  input  logic              irq_en,
  input  logic              irq_ack,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              irq,
  output logic              irq_pend,
  output logic              parked,
  output logic              buf_empty
);
  import rxdma_pkg::*;

  localparam int CNT_W = LEN_W;

  chan_state_t       state;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] ptr;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] slot_nx;
  logic [CNT_W-1:0]  buf_len;
  logic              info_irq;
  logic              mid;
  logic              blk_sof;
  logic              blk_eof;
  logic              stop_req;

  logic [CNT_W-1:0]  cnt;
  logic [1:0]        lane;
  logic [31:0]       word;

  // named internal events
  logic take;
  logic slot_end;
  logic word_wr;
  logic status_wr;
  logic irq_evt;
  logic last_slot;

  // address of the pointer (st=0) or completion word (st=1) of slot k
  function automatic logic [ADDR_W-1:0] field_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [SLOT_W-1:0] k,
                                                   input logic st);
    return base + ADDR_W'(2) + ADDR_W'({k, 1'b0}) + ADDR_W'(st);
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [CNT_W-1:0] n);
    return base + ADDR_W'(n[CNT_W-1:2]);
  endfunction

  assign in_ready  = (state == ST_STREAM) && !(stop_req && (cnt == '0));
  assign take      = in_valid && in_ready;
  assign slot_end  = take && (((cnt + CNT_W'(1)) == buf_len) || in_last);
  assign word_wr   = take && ((lane == 2'd3) || slot_end);
  assign status_wr = (state == ST_STATUS);
  assign irq_evt   = status_wr && info_irq && (!cfg_eof_only || blk_eof);
  assign slot_nx   = slot + SLOT_W'(1);
  assign last_slot = (slot_nx == cfg_slots);
  assign parked    = (state == ST_PARK);
  assign buf_empty = (state == ST_IDLE);

  rxdma_packer #(.CNT_W(CNT_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state == ST_PTR_GET),
    .take    (take),
    .flush   (word_wr),
    .byte_in (in_data),
    .cnt     (cnt),
    .lane    (lane),
    .word    (word)
  );

  rxdma_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (irq_evt),
    .ack   (irq_ack),
    .en    (irq_en),
    .pend  (irq_pend),
    .irq   (irq)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_INFO_REQ: begin
        mem_req  = 1'b1;
        mem_addr = cur + ADDR_W'(1);
      end
      ST_PTR_REQ: begin
        mem_req  = 1'b1;
        mem_addr = field_addr(cur, slot, 1'b0);
      end
      ST_STREAM: begin
        if (word_wr) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = word_addr(ptr, cnt);
          mem_wdata = word;
        end
      end
      ST_STATUS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = field_addr(cur, slot, 1'b1);
        mem_wdata = pack_status(cnt, blk_sof, blk_eof, info_irq);
      end
      ST_NEXT_REQ: begin
        mem_req  = 1'b1;
        mem_addr = cur;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  stop_req <= 1'b0;
    else if (state == ST_IDLE)   stop_req <= 1'b0;
    else if (cmd_stop)           stop_req <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur      <= '0;
      ptr      <= '0;
      slot     <= '0;
      buf_len  <= '0;
      info_irq <= 1'b0;
      mid      <= 1'b0;
      blk_sof  <= 1'b0;
      blk_eof  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_activate) begin
            cur   <= start_ptr;
            mid   <= 1'b0;
            state <= ST_INFO_REQ;
          end
        end
        ST_INFO_REQ: state <= ST_INFO_GET;
        ST_INFO_GET: begin
          buf_len  <= mem_rdata[CNT_W-1:0];
          info_irq <= mem_rdata[SETUP_IRQ_B];
          slot     <= '0;
          state    <= ST_PTR_REQ;
        end
        ST_PTR_REQ: state <= ST_PTR_GET;
        ST_PTR_GET: begin
          ptr   <= mem_rdata[ADDR_W-1:0];
          state <= ST_STREAM;
        end
        ST_STREAM: begin
          if (slot_end) begin
            blk_sof <= !mid;
            blk_eof <= in_last;
            mid     <= !in_last;
            state   <= ST_STATUS;
          end else if (stop_req && (cnt == '0)) begin
            state <= ST_IDLE;
          end
        end
        ST_STATUS: begin
          if (last_slot) begin
            state <= ST_NEXT_REQ;
          end else begin
            slot  <= slot_nx;
            state <= stop_req ? ST_IDLE : ST_PTR_REQ;
          end
        end
        ST_NEXT_REQ: state <= ST_NEXT_GET;
        ST_NEXT_GET: begin
          if (mem_rdata[0]) begin
            state <= ST_PARK;
          end else begin
            cur   <= mem_rdata[ADDR_W-1:0];
            state <= ST_INFO_REQ;
          end
        end
        ST_PARK: begin
          if (stop_req)        state <= ST_IDLE;
          else if (cmd_reload) state <= ST_NEXT_REQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxdma_chk.sv
module rxdma_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic take,
  input logic mem_req,
  input logic status_wr,
  input logic irq_evt,
  input logic irq_pend,
  input logic irq_ack,
  input logic parked,
  input logic buf_empty
);

  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(irq_evt)); // R9

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_ack) |=> irq_pend); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_evt) |=> !irq_pend); // R9

  AST_PARK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> !in_ready); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> (!mem_req && !in_ready)); // R10

  AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |-> $past(take)); // R4

endmodule

bind rxdma_channel rxdma_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .take      (take),
  .mem_req   (mem_req),
  .status_wr (status_wr),
  .irq_evt   (irq_evt),
  .irq_pend  (irq_pend),
  .irq_ack   (irq_ack),
  .parked    (parked),
  .buf_empty (buf_empty)
);

// File: tb/test_rxdma_channel.sv
module test_rxdma_channel;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int BLK_A = 'h100;
  localparam int BLK_B = 'h120;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_activate = 0, cmd_reload = 0, cmd_stop = 0;
  logic [AW-1:0] start_ptr = '0;
  logic [SW-1:0] cfg_slots = 4'd2;
  logic cfg_eof_only = 0, irq_en = 1, irq_ack = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = '0;
  logic in_ready, mem_req, mem_we, irq, irq_pend, parked, buf_empty;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  rxdma_channel #(.ADDR_W(AW), .SLOT_W(SW)) i_rxdma_channel (
    .clk(clk), .rst_n(rst_n), .cmd_activate(cmd_activate), .cmd_reload(cmd_reload),
    .cmd_stop(cmd_stop), .start_ptr(start_ptr), .cfg_slots(cfg_slots),
    .cfg_eof_only(cfg_eof_only), .irq_en(irq_en), .irq_ack(irq_ack),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq), .irq_pend(irq_pend), .parked(parked),
    .buf_empty(buf_empty)
  );

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  int checks = 0;
  int bad = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected memory writes, in order
  int    q_addr[$];
  int    q_data[$];
  string q_tag[$];

  always @(negedge clk) begin
    #1;
    if (rst_n && mem_req && mem_we) begin
      if (q_addr.size() == 0) begin
        check(0, "R3 unexpected write", {32'(mem_addr), mem_wdata}, 64'h0);
      end else begin
        int a, d; string t;
        a = q_addr.pop_front(); d = q_data.pop_front(); t = q_tag.pop_front();
        check((mem_addr == 32'(a)) && (mem_wdata == 32'(d)), t,
              {32'(mem_addr), mem_wdata}, {32'(a), 32'(d)});
      end
    end
  end

  // behavioural channel model
  int m_dcb, m_slot, m_cnt, m_len, m_ptr;
  bit m_mid, m_parked, m_intr;
  logic [31:0] m_acc;

  task automatic push(input int a, input int d, input string t);
    q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
  endtask

  task automatic model_start(input int head);
    m_dcb = head; m_slot = 0; m_cnt = 0; m_mid = 0; m_parked = 0; m_acc = 0;
  endtask

  task automatic model_reload();
    logic [31:0] nxt;
    nxt = mem[m_dcb];
    if (!nxt[0]) begin m_dcb = int'(nxt); m_parked = 0; end
  endtask

  task automatic model_byte(input logic [7:0] b, input bit last);
    int lane; bit done; logic [31:0] st; logic [31:0] nxt;
    if (m_cnt == 0) begin
      m_ptr  = int'(mem[m_dcb + 2 + 2*m_slot]);
      m_len  = int'(mem[m_dcb + 1][15:0]);
      m_intr = mem[m_dcb + 1][18];
    end
    lane  = m_cnt % 4;
    m_acc = m_acc | (32'(b) << (8*lane));
    m_cnt++;
    done = (m_cnt == m_len) || last;
    if (lane == 3 || done) begin
      push(m_ptr + (m_cnt-1)/4, int'(m_acc), "R1 R2 R3 data word");
      m_acc = 0;
    end
    if (done) begin
      st = 32'(m_cnt) | (32'(!m_mid) << 16) | (32'(last) << 17) | (32'(m_intr) << 18) | (32'h1 << 19);
      push(m_dcb + 3 + 2*m_slot, int'(st), "R1 R4 R5 completion word");
      m_mid = !last; m_cnt = 0; m_slot++;
      if (m_slot == int'(cfg_slots)) begin
        m_slot = 0;
        nxt = mem[m_dcb];
        if (nxt[0]) m_parked = 1; else m_dcb = int'(nxt);
      end
    end
  endtask

  function automatic logic [7:0] fb(input int f, input int i);
    return 8'(f*32 + i + 1);
  endfunction

  task automatic send(input int f, input int n, input bit last_end, input bit do_model);
    for (int i = 0; i < n; i++) begin
      if (do_model) model_byte(fb(f, i), last_end && (i == n-1));
      @(negedge clk);
      in_valid = 1; in_data = fb(f, i); in_last = last_end && (i == n-1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_drain();
    while (q_addr.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    #1;
  endtask

  task automatic ack_irq();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    #1;
    check(irq == 0 && irq_pend == 0, "R9 ack clears", 64'(irq_pend), 64'h0);
  endtask

  task automatic pulse_reload();
    @(negedge clk); cmd_reload = 1;
    @(negedge clk); cmd_reload = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[BLK_A]     = BLK_B;
    mem[BLK_A + 1] = 32'h8 | (32'h1 << 18);
    mem[BLK_A + 2] = 'h200;
    mem[BLK_A + 4] = 'h204;
    mem[BLK_B]     = 32'h1;
    mem[BLK_B + 1] = 32'h8;
    mem[BLK_B + 2] = 'h208;
    mem[BLK_B + 4] = 'h20C;

    repeat (4) @(negedge clk);
    #1;
    // R11 reset state
    check(buf_empty == 1, "R11 buf_empty", 64'(buf_empty), 64'h1);
    check(in_ready == 0 && mem_req == 0, "R11 quiet", {in_ready, mem_req}, 64'h0);
    check(irq == 0 && parked == 0, "R11 irq parked", {irq, parked}, 64'h0);
    @(negedge clk); rst_n = 1;

    // R8 activate from start pointer; single-slot frame
    model_start(BLK_A);
    @(negedge clk); start_ptr = BLK_A; cmd_activate = 1;
    @(negedge clk); cmd_activate = 0;
    send(1, 5, 1, 1);
    wait_drain();
    check(irq == 1, "R9 irq after flagged slot", 64'(irq), 64'h1);
    ack_irq();

    // R5 frame spanning blocks; R8 activate ignored while running
    fork
      send(2, 12, 1, 1);
      begin
        repeat (3) @(negedge clk);
        start_ptr = 'h300; cmd_activate = 1;
        @(negedge clk); cmd_activate = 0;
      end
    join
    wait_drain();
    check(mem['h303] == 0 && mem['h300] == 0, "R8 activate ignored", 64'(mem['h303]), 64'h0);
    check(irq == 1, "R9 irq from first block slot", 64'(irq), 64'h1);
    ack_irq();

    // R6 end of chain parks; R9 no interrupt when the flag is clear
    send(3, 3, 1, 1);
    wait_drain();
    check(parked == 1, "R6 parked", 64'(parked), 64'h1);
    check(in_ready == 0, "R6 ready low", 64'(in_ready), 64'h0);
    check(irq_pend == 0, "R9 flag clear gives no irq", 64'(irq_pend), 64'h0);

    fork
      send(4, 4, 1, 0);
      begin
        for (int c = 0; c < 6; c++) begin
          @(negedge clk); #1;
          check(in_ready == 0, "R6 stall while parked", 64'(in_ready), 64'h0);
        end
        pulse_reload();
        repeat (8) @(negedge clk);
        #1;
        check(parked == 1, "R7 reload on invalid link stays parked", 64'(parked), 64'h1);
        mem[BLK_B]     = BLK_A;
        mem[BLK_B + 1] = 32'h8 | (32'h1 << 18);
        model_reload();
        for (int i = 0; i < 4; i++) model_byte(fb(4, i), i == 3);
        pulse_reload();
      end
    join
    wait_drain();
    check(parked == 0, "R7 resumed after reload", 64'(parked), 64'h0);
    check(irq == 1, "R7 held frame delivered", 64'(irq), 64'h1);
    ack_irq();

    // R9 end-of-frame-only interrupt
    cfg_eof_only = 1;
    send(5, 8, 0, 1);
    wait_drain();
    check(irq_pend == 0, "R9 eof-only suppresses mid-frame slot", 64'(irq_pend), 64'h0);
    send(6, 1, 1, 1);
    wait_drain();
    check(irq == 1, "R9 eof-only fires on frame end", 64'(irq), 64'h1);
    ack_irq();
    @(negedge clk); cfg_eof_only = 0;

    // R9 masking
    irq_en = 0;
    send(7, 2, 1, 1);
    wait_drain();
    check(irq == 0 && irq_pend == 1, "R9 masked but pending", {irq, irq_pend}, 64'h1);
    @(negedge clk); irq_en = 1;
    #1;
    check(irq == 1, "R9 unmask shows pending", 64'(irq), 64'h1);
    ack_irq();

    // R10 stop finishes the slot in progress
    fork
      send(8, 6, 1, 1);
      begin
        repeat (2) @(negedge clk);
        cmd_stop = 1;
        @(negedge clk); cmd_stop = 0;
      end
    join
    wait_drain();
    check(buf_empty == 1, "R10 drained to idle", 64'(buf_empty), 64'h1);
    ack_irq();
    @(negedge clk); in_valid = 1; in_data = 8'hEE; in_last = 1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk); #1;
      check(in_ready == 0, "R10 no intake when idle", 64'(in_ready), 64'h0);
    end
    in_valid = 0; in_last = 0;

    // R8 re-activate at a different head
    model_start(BLK_B);
    @(negedge clk); start_ptr = BLK_B; cmd_activate = 1;
    @(negedge clk); cmd_activate = 0;
    send(9, 2, 1, 1);
    wait_drain();
    check(buf_empty == 0, "R8 running after activate", 64'(buf_empty), 64'h0);
    check(q_addr.size() == 0, "R3 all writes seen", 64'(q_addr.size()), 64'h0);
    finish_run();
  end

endmodule